// File: doc/BRIEF.md
# Trace Buffer Write DMA

This block receives the merged trace stream, one data word per handshake, and stores it in a circular trace buffer in memory. It acts as an AXI write master. Incoming words collect in a small gather FIFO. When enough words are present, the block issues a fixed-length INCR burst. Each burst is tagged with a low QoS value that software chooses, so that trace writes give way to functional traffic. A flush request pushes out whatever partial data remains.

Software programs the block through an AXI4-Lite register set. The registers hold the buffer start, the buffer length in bytes, the QoS value, the enable and flush controls, and a status word. The status word reports that the buffer has wrapped, that a write error occurred, and whether a burst is in progress. The current write pointer can also be read. The pointer advances only when memory answers a burst with OKAY. When it reaches the end of the buffer it returns to the start and raises the sticky wrapped flag.

A four-state machine drives the write channels. IDLE goes to ADDR on a launch decision. ADDR goes to DATA when the address is accepted. DATA goes to RESP after the last beat is accepted. RESP goes back to IDLE when the write response arrives.

Top module: `tbw_top`

## Requirements
- R1: After reset, every register reads zero, the stream input is not ready and no write address is offered.
- R2: Once the gather FIFO holds BURST_LEN words, one burst starts at the write pointer with these fields: awlen = BURST_LEN-1, awburst = 2'b01 (INCR), awsize = log2 of the data bytes, and awqos taken from the QOS register (offset 0x0C, bits 3:0).
- R3: Write beats carry the stream words in arrival order, with every strobe set and wlast on the final beat. They follow the accepted address, and wvalid stays high until wready.
- R4: No new write address is offered until the response of the previous burst has been accepted.
- R5: The write pointer (WPTR, offset 0x10) advances by the burst's byte count only on an OKAY response (bresp 2'b00), and changes at no other time except a base reload.
- R6: When the pointer reaches base+size it returns to base and sets the sticky wrapped flag (STATUS offset 0x14, bit 0). Writing 1 to that bit clears it.
- R7: Fewer than BURST_LEN words stay in the FIFO until a flush is written (CTRL offset 0x00, bit 1, self-clearing). The flush then sends them as one shorter burst.
- R8: A non-OKAY response sets the error flag (STATUS bit 1), clears enable (CTRL bit 0), leaves the pointer unchanged and stops input. Writing 1 to the enable bit clears the error.
- R9: Clearing enable lets a burst in progress finish. After that the block stays idle, and the stream input is held not ready for as long as enable is 0.
- R10: STATUS bit 2 reads 1 while the state machine is outside IDLE.
- R11: No burst runs past base+size or across a 4 KB address boundary. The burst length is cut to fit the space that remains.
- R12: A write to BASE (offset 0x04) reloads the write pointer with the new base. SIZE is at offset 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trc_valid | input | 1 | Trace word valid |
| trc_ready | output | 1 | Trace word accepted |
| trc_data | input | DW | Trace word |
| cfg_awaddr | input | 5 | Register write address |
| cfg_awvalid | input | 1 | Register write address valid |
| cfg_awready | output | 1 | Register write address ready |
| cfg_wdata | input | 32 | Register write data |
| cfg_wvalid | input | 1 | Register write data valid |
| cfg_wready | output | 1 | Register write data ready |
| cfg_bresp | output | 2 | Register write response |
| cfg_bvalid | output | 1 | Register write response valid |
| cfg_bready | input | 1 | Register write response ready |
| cfg_araddr | input | 5 | Register read address |
| cfg_arvalid | input | 1 | Register read address valid |
| cfg_arready | output | 1 | Register read address ready |
| cfg_rdata | output | 32 | Register read data |
| cfg_rresp | output | 2 | Register read response |
| cfg_rvalid | output | 1 | Register read data valid |
| cfg_rready | input | 1 | Register read data ready |
| m_awaddr | output | AW | Burst start address |
| m_awlen | output | 8 | Beats minus one |
| m_awsize | output | 3 | Bytes per beat, log2 |
| m_awburst | output | 2 | Burst type (INCR) |
| m_awqos | output | 4 | Quality of service |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DW | Write data |
| m_wstrb | output | DW/8 | Write strobes |
| m_wlast | output | 1 | Last beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The bench builds the block with a 32-bit data path and BURST_LEN of 4, which gives 16-byte bursts and an 8-word gather FIFO. The buffer is 64 bytes, so it holds four full bursts. With these values the bench reaches the end of the buffer within a few dozen words. After a three-beat flush the pointer is left off the burst grid, so the sequence runs into a one-beat tail burst, then the wrap back to base. A slave model that can delay its response holds a burst open long enough to disable the block mid-burst.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_RESP} tbw_state_e;

    localparam logic [4:0] REG_CTRL = 5'h00;
    localparam logic [4:0] REG_BASE = 5'h04;
    localparam logic [4:0] REG_SIZE = 5'h08;
    localparam logic [4:0] REG_QOS  = 5'h0C;
    localparam logic [4:0] REG_WPTR = 5'h10;
    localparam logic [4:0] REG_STAT = 5'h14;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/tbw_regs.sv
module tbw_regs
    import tbw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    l_awaddr,
    input  logic          l_awvalid,
    output logic          l_awready,
    input  logic [31:0]   l_wdata,
    input  logic          l_wvalid,
    output logic          l_wready,
    output logic [1:0]    l_bresp,
    output logic          l_bvalid,
    input  logic          l_bready,
    input  logic [4:0]    l_araddr,
    input  logic          l_arvalid,
    output logic          l_arready,
    output logic [31:0]   l_rdata,
    output logic [1:0]    l_rresp,
    output logic          l_rvalid,
    input  logic          l_rready,
    input  logic [AW-1:0] wptr_i,
    input  logic          busy_i,
    input  logic          wrap_set_i,
    input  logic          err_set_i,
    output logic          en_o,
    output logic          flush_o,
    output logic          base_ld_o,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] size_o,
    output logic [3:0]    qos_o,
    output logic          wrapped_o,
    output logic          error_o
);
    logic wr_fire;
    logic rd_fire;

    assign wr_fire   = l_awvalid && l_wvalid && !l_bvalid;
    assign l_awready = wr_fire;
    assign l_wready  = wr_fire;
    assign l_arready = !l_rvalid;
    assign rd_fire   = l_arvalid && !l_rvalid;
    assign l_bresp   = RESP_OKAY;
    assign l_rresp   = RESP_OKAY;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o      <= 1'b0;
            flush_o   <= 1'b0;
            base_ld_o <= 1'b0;
            base_o    <= '0;
            size_o    <= '0;
            qos_o     <= '0;
            wrapped_o <= 1'b0;
            error_o   <= 1'b0;
            l_bvalid  <= 1'b0;
        end else begin
            flush_o   <= 1'b0;
            base_ld_o <= 1'b0;
            if (l_bvalid && l_bready) l_bvalid <= 1'b0;
            if (wr_fire) begin
                l_bvalid <= 1'b1;
                case (l_awaddr)
                    REG_CTRL: begin
                        en_o    <= l_wdata[0];
                        flush_o <= l_wdata[1];
                        if (l_wdata[0]) error_o <= 1'b0;
                    end
                    REG_BASE: begin
                        base_o    <= l_wdata[AW-1:0];
                        base_ld_o <= 1'b1;
                    end
                    REG_SIZE: size_o <= l_wdata[AW-1:0];
                    REG_QOS:  qos_o  <= l_wdata[3:0];
                    REG_STAT: if (l_wdata[0]) wrapped_o <= 1'b0;
                    default: ;
                endcase
            end
            if (wrap_set_i) wrapped_o <= 1'b1;
            if (err_set_i) begin
                error_o <= 1'b1;
                en_o    <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_rvalid <= 1'b0;
            l_rdata  <= '0;
        end else if (rd_fire) begin
            l_rvalid <= 1'b1;
            case (l_araddr)
                REG_CTRL: l_rdata <= {31'd0, en_o};
                REG_BASE: l_rdata <= 32'(base_o);
                REG_SIZE: l_rdata <= 32'(size_o);
                REG_QOS:  l_rdata <= {28'd0, qos_o};
                REG_WPTR: l_rdata <= 32'(wptr_i);
                REG_STAT: l_rdata <= {29'd0, busy_i, error_o, wrapped_o};
                default:  l_rdata <= '0;
            endcase
        end else if (l_rvalid && l_rready) begin
            l_rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/tbw_fifo.sv
module tbw_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              din,
    input  logic                       pop,
    output logic [DW-1:0]              dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign dout = mem[rd_ptr];
endmodule

// File: rtl/tbw_fsm.sv
module tbw_fsm
    import tbw_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int BL = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic                        error,
    input  logic                        flush_i,
    input  logic                        base_ld,
    input  logic [AW-1:0]               base,
    input  logic [AW-1:0]               size,
    input  logic [$clog2(2*BL+1)-1:0]   count,
    output logic [AW-1:0]               m_awaddr,
    output logic [7:0]                  m_awlen,
    output logic                        m_awvalid,
    input  logic                        m_awready,
    output logic                        m_wlast,
    output logic                        m_wvalid,
    input  logic                        m_wready,
    input  logic [1:0]                  m_bresp,
    input  logic                        m_bvalid,
    output logic                        m_bready,
    output logic [AW-1:0]               wptr_o,
    output logic                        busy_o,
    output logic                        wrap_set_o,
    output logic                        err_set_o
);
    localparam int BSH = $clog2(DW/8);
    localparam int LW  = $clog2(BL+1);
    localparam int CW  = $clog2(2*BL+1);

    tbw_state_e    state, state_nx;
    logic [AW-1:0] wptr, buf_end, room_end, room_4k, nxt;
    logic [LW-1:0] cap, blen, beat;
    logic          flush_pend, launch, ok_fire, wrap_hit;

    assign buf_end  = base + size;
    assign room_end = (buf_end - wptr) >> BSH;
    assign room_4k  = (AW'(4096) - AW'(wptr[11:0])) >> BSH;
    assign nxt      = wptr + (AW'(blen) << BSH);
    assign wrap_hit = (nxt >= buf_end);

    always_comb begin
        cap = LW'(BL);
        if (room_end < AW'(BL)) cap = LW'(room_end);
        if (room_4k < AW'(cap)) cap = LW'(room_4k);
    end

    assign launch = (state == ST_IDLE) && en && !error && (cap != '0) && (count != '0)
                    && ((count >= CW'(cap)) || flush_pend);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (launch) state_nx = ST_ADDR;
            ST_ADDR: if (m_awready) state_nx = ST_DATA;
            ST_DATA: if (m_wready && m_wlast) state_nx = ST_RESP;
            ST_RESP: if (m_bvalid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        m_awvalid = (state == ST_ADDR);
        m_wvalid  = (state == ST_DATA);
        m_bready  = (state == ST_RESP);
        m_wlast   = (state == ST_DATA) && (beat == blen - 1'b1);
        busy_o    = (state != ST_IDLE);
    end

    assign ok_fire    = (state == ST_RESP) && m_bvalid && (m_bresp == RESP_OKAY);
    assign err_set_o  = (state == ST_RESP) && m_bvalid && (m_bresp != RESP_OKAY);
    assign wrap_set_o = ok_fire && wrap_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blen       <= '0;
            beat       <= '0;
            wptr       <= '0;
            flush_pend <= 1'b0;
        end else begin
            if (launch) begin
                blen <= (count >= CW'(cap)) ? cap : LW'(count);
                beat <= '0;
            end else if (m_wvalid && m_wready) begin
                beat <= beat + 1'b1;
            end
            if (flush_i)
                flush_pend <= 1'b1;
            else if (launch && (count <= CW'(cap)))
                flush_pend <= 1'b0;
            else if ((state == ST_IDLE) && (count == '0))
                flush_pend <= 1'b0;
            if (base_ld)      wptr <= base;
            else if (ok_fire) wptr <= wrap_hit ? base : nxt;
        end
    end

    assign m_awaddr = wptr;
    assign m_awlen  = 8'(blen - 1'b1);
    assign wptr_o   = wptr;
endmodule

// File: rtl/tbw_top.sv
module tbw_top
    import tbw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int BURST_LEN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trc_valid,
    output logic            trc_ready,
    input  logic [DW-1:0]   trc_data,
    input  logic [4:0]      cfg_awaddr,
    input  logic            cfg_awvalid,
    output logic            cfg_awready,
    input  logic [31:0]     cfg_wdata,
    input  logic            cfg_wvalid,
    output logic            cfg_wready,
    output logic [1:0]      cfg_bresp,
    output logic            cfg_bvalid,
    input  logic            cfg_bready,
    input  logic [4:0]      cfg_araddr,
    input  logic            cfg_arvalid,
    output logic            cfg_arready,
    output logic [31:0]     cfg_rdata,
    output logic [1:0]      cfg_rresp,
    output logic            cfg_rvalid,
    input  logic            cfg_rready,
    output logic [AW-1:0]   m_awaddr,
    output logic [7:0]      m_awlen,
    output logic [2:0]      m_awsize,
    output logic [1:0]      m_awburst,
    output logic [3:0]      m_awqos,
    output logic            m_awvalid,
    input  logic            m_awready,
    output logic [DW-1:0]   m_wdata,
    output logic [DW/8-1:0] m_wstrb,
    output logic            m_wlast,
    output logic            m_wvalid,
    input  logic            m_wready,
    input  logic [1:0]      m_bresp,
    input  logic            m_bvalid,
    output logic            m_bready
);
    localparam int DEPTH = 2 * BURST_LEN;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int BSH   = $clog2(DW/8);

    logic          cfg_en, cfg_flush, base_ld, cfg_wrapped, cfg_error;
    logic [AW-1:0] cfg_base, cfg_size, wptr;
    logic [3:0]    cfg_qos;
    logic          busy, wrap_set, err_set;
    logic [CW-1:0] fifo_cnt;

    assign trc_ready = cfg_en && (fifo_cnt < CW'(DEPTH));
    assign m_awsize  = 3'(BSH);
    assign m_awburst = BURST_INCR;
    assign m_awqos   = cfg_qos;
    assign m_wstrb   = '1;

    tbw_regs #(.AW(AW)) u_regs (
        .clk, .rst_n,
        .l_awaddr(cfg_awaddr), .l_awvalid(cfg_awvalid), .l_awready(cfg_awready),
        .l_wdata(cfg_wdata), .l_wvalid(cfg_wvalid), .l_wready(cfg_wready),
        .l_bresp(cfg_bresp), .l_bvalid(cfg_bvalid), .l_bready(cfg_bready),
        .l_araddr(cfg_araddr), .l_arvalid(cfg_arvalid), .l_arready(cfg_arready),
        .l_rdata(cfg_rdata), .l_rresp(cfg_rresp), .l_rvalid(cfg_rvalid), .l_rready(cfg_rready),
        .wptr_i(wptr), .busy_i(busy), .wrap_set_i(wrap_set), .err_set_i(err_set),
        .en_o(cfg_en), .flush_o(cfg_flush), .base_ld_o(base_ld),
        .base_o(cfg_base), .size_o(cfg_size), .qos_o(cfg_qos),
        .wrapped_o(cfg_wrapped), .error_o(cfg_error)
    );

    tbw_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk, .rst_n,
        .push(trc_valid && trc_ready), .din(trc_data),
        .pop(m_wvalid && m_wready), .dout(m_wdata),
        .count(fifo_cnt)
    );

    tbw_fsm #(.AW(AW), .DW(DW), .BL(BURST_LEN)) u_fsm (
        .clk, .rst_n,
        .en(cfg_en), .error(cfg_error), .flush_i(cfg_flush), .base_ld(base_ld),
        .base(cfg_base), .size(cfg_size), .count(fifo_cnt),
        .m_awaddr, .m_awlen, .m_awvalid, .m_awready,
        .m_wlast, .m_wvalid, .m_wready,
        .m_bresp, .m_bvalid, .m_bready,
        .wptr_o(wptr), .busy_o(busy), .wrap_set_o(wrap_set), .err_set_o(err_set)
    );
endmodule

// File: rtl/tbw_chk.sv
module tbw_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          aw_valid,
    input logic          aw_ready,
    input logic [AW-1:0] aw_addr,
    input logic          w_valid,
    input logic          w_ready,
    input logic          b_valid,
    input logic          b_ready,
    input logic [1:0]    b_resp,
    input logic          en,
    input logic          error,
    input logic          base_ld,
    input logic          in_ready,
    input logic [AW-1:0] wptr,
    input logic [AW-1:0] base,
    input logic [AW-1:0] size
);
    logic inflight;

    always_ff @(posedge clk) begin
        if (!rst_n)                  inflight <= 1'b0;
        else if (aw_valid && aw_ready) inflight <= 1'b1;
        else if (b_valid && b_ready)   inflight <= 1'b0;
    end

    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr)); // R2
    AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && !w_ready |=> w_valid); // R3
    AST_ONE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        inflight |-> !aw_valid); // R4
    AST_PTR_ON_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_valid && b_ready && b_resp == 2'b00) && !base_ld |=> $stable(wptr)); // R5
    AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !aw_valid); // R8
    AST_ERR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> !en); // R8
    AST_BP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !in_ready); // R9
    AST_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        aw_valid |-> (aw_addr >= base) && (aw_addr < base + size)); // R11
endmodule

bind tbw_top tbw_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(m_awvalid), .aw_ready(m_awready), .aw_addr(m_awaddr),
    .w_valid(m_wvalid), .w_ready(m_wready),
    .b_valid(m_bvalid), .b_ready(m_bready), .b_resp(m_bresp),
    .en(cfg_en), .error(cfg_error), .base_ld(base_ld), .in_ready(trc_ready),
    .wptr(wptr), .base(cfg_base), .size(cfg_size)
);

// File: tb/tbw_top_tb.sv
module tbw_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          trc_valid = 1'b0, trc_ready;
    logic [DW-1:0] trc_data = '0;
    logic [4:0]    cfg_awaddr = '0, cfg_araddr = '0;
    logic          cfg_awvalid = 1'b0, cfg_awready, cfg_wvalid = 1'b0, cfg_wready;
    logic [31:0]   cfg_wdata = '0, cfg_rdata;
    logic [1:0]    cfg_bresp, cfg_rresp;
    logic          cfg_bvalid, cfg_bready = 1'b1, cfg_arvalid = 1'b0, cfg_arready;
    logic          cfg_rvalid, cfg_rready = 1'b1;
    logic [AW-1:0] m_awaddr;
    logic [7:0]    m_awlen;
    logic [2:0]    m_awsize;
    logic [1:0]    m_awburst, m_bresp = 2'b00;
    logic [3:0]    m_awqos;
    logic          m_awvalid, m_awready = 1'b1, m_wlast, m_wvalid, m_wready = 1'b1;
    logic [DW-1:0] m_wdata;
    logic [DW/8-1:0] m_wstrb;
    logic          m_bvalid = 1'b0, m_bready;

    tbw_top #(.AW(AW), .DW(DW), .BURST_LEN(BL)) u_dut (
        .clk, .rst_n, .trc_valid, .trc_ready, .trc_data,
        .cfg_awaddr, .cfg_awvalid, .cfg_awready, .cfg_wdata, .cfg_wvalid, .cfg_wready,
        .cfg_bresp, .cfg_bvalid, .cfg_bready, .cfg_araddr, .cfg_arvalid, .cfg_arready,
        .cfg_rdata, .cfg_rresp, .cfg_rvalid, .cfg_rready,
        .m_awaddr, .m_awlen, .m_awsize, .m_awburst, .m_awqos, .m_awvalid, .m_awready,
        .m_wdata, .m_wstrb, .m_wlast, .m_wvalid, .m_wready,
        .m_bresp, .m_bvalid, .m_bready
    );

    int n_checks = 0, n_fail = 0;
    logic [DW-1:0] sent [64];
    logic [DW-1:0] wlog [64];
    int s_idx = 0, w_idx = 0, aw_cnt = 0, b_cnt = 0;
    int wbeat = 0, wlast_bad = 0, strb_bad = 0, overlap = 0;
    logic [AW-1:0] last_addr = '0;
    logic [7:0] last_len = '0;
    logic [3:0] last_qos = '0;
    logic [1:0] last_burst = '0;
    logic [2:0] last_size = '0;
    logic [1:0] resp_mode = 2'b00;
    int b_delay = 0, bwait = 0;
    logic bpend = 1'b0, bfire = 1'b0, outst = 1'b0;

    // slave responder and channel monitor, evaluated away from the rising edge
    always @(negedge clk) begin
        if (!rst_n) begin
            m_bvalid = 1'b0; bpend = 1'b0; bfire = 1'b0; outst = 1'b0;
        end else begin
            if (bfire) begin m_bvalid = 1'b0; bfire = 1'b0; outst = 1'b0; end
            if (bpend) begin
                if (bwait == 0) begin m_bvalid = 1'b1; m_bresp = resp_mode; bpend = 1'b0; end
                else bwait--;
            end
            if (m_bvalid && m_bready) begin bfire = 1'b1; b_cnt++; end
            if (m_awvalid && m_awready) begin
                if (outst) overlap++;
                outst = 1'b1;
                aw_cnt++; wbeat = 0;
                last_addr = m_awaddr; last_len = m_awlen; last_qos = m_awqos;
                last_burst = m_awburst; last_size = m_awsize;
            end
            if (m_wvalid && m_wready) begin
                if (w_idx < 64) wlog[w_idx] = m_wdata;
                w_idx++;
                if (m_wlast != (wbeat == int'(last_len))) wlast_bad++;
                if (m_wstrb != '1) strb_bad++;
                wbeat++;
                if (m_wlast) begin bpend = 1'b1; bwait = b_delay; end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_awaddr = a; cfg_wdata = d; cfg_awvalid = 1'b1; cfg_wvalid = 1'b1;
        #1;
        while (!cfg_awready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        cfg_awvalid = 1'b0; cfg_wvalid = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_araddr = a; cfg_arvalid = 1'b1;
        #1;
        while (!cfg_arready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        cfg_arvalid = 1'b0;
        d = cfg_rdata;
        @(posedge clk); #1;
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge clk);
        trc_valid = 1'b1; trc_data = d;
        #1;
        while (!trc_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        trc_valid = 1'b0;
        sent[s_idx] = d; s_idx++;
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) push(32'hA000_0000 + 32'(s_idx));
    endtask

    task automatic wait_b(input int n);
        for (int i = 0; i < 400 && b_cnt < n; i++) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    logic [31:0] rd;

    task automatic t_reset();
        reg_rd(5'h00, rd); chk("R1 ctrl", rd, 0);
        reg_rd(5'h14, rd); chk("R1 status", rd, 0);
        reg_rd(5'h10, rd); chk("R1 wptr", rd, 0);
        chk("R1 trc_ready", 32'(trc_ready), 0);
        chk("R1 awvalid", 32'(m_awvalid), 0);
    endtask

    task automatic t_config();
        reg_wr(5'h04, 32'h1000);
        reg_wr(5'h08, 32'd64);
        reg_wr(5'h0C, 32'd2);
        reg_rd(5'h0C, rd); chk("R2 qos readback", rd, 2);
        reg_rd(5'h10, rd); chk("R12 wptr after base", rd, 32'h1000);
        reg_wr(5'h00, 32'd1);
        chk("R9 ready when enabled", 32'(trc_ready), 1);
    endtask

    task automatic t_full_burst();
        push_n(4);
        wait_b(1);
        chk("R2 one burst", aw_cnt, 1);
        chk("R2 awaddr", last_addr, 32'h1000);
        chk("R2 awlen", 32'(last_len), 3);
        chk("R2 awqos", 32'(last_qos), 2);
        chk("R2 awburst", 32'(last_burst), 1);
        chk("R2 awsize", 32'(last_size), 2);
        reg_rd(5'h10, rd); chk("R5 wptr advance", rd, 32'h1010);
    endtask

    task automatic t_flush();
        push_n(3);
        repeat (20) @(posedge clk);
        chk("R7 partial held", aw_cnt, 1);
        reg_wr(5'h00, 32'd3);
        wait_b(2);
        chk("R7 flush burst", aw_cnt, 2);
        chk("R7 flush awlen", 32'(last_len), 2);
        chk("R7 flush awaddr", last_addr, 32'h1010);
        reg_rd(5'h10, rd); chk("R5 wptr after flush", rd, 32'h101C);
    endtask

    task automatic t_wrap();
        push_n(9);
        wait_b(5);
        chk("R11 tail burst count", aw_cnt, 5);
        chk("R11 tail awaddr", last_addr, 32'h103C);
        chk("R11 tail awlen", 32'(last_len), 0);
        reg_rd(5'h10, rd); chk("R6 wptr back to base", rd, 32'h1000);
        reg_rd(5'h14, rd); chk("R6 wrapped set", rd, 1);
        reg_wr(5'h14, 32'd1);
        reg_rd(5'h14, rd); chk("R6 wrapped cleared", rd, 0);
    endtask

    task automatic t_error();
        resp_mode = 2'b10;
        push_n(4);
        wait_b(6);
        resp_mode = 2'b00;
        reg_rd(5'h14, rd); chk("R8 error flag", rd, 2);
        reg_rd(5'h00, rd); chk("R8 enable cleared", rd, 0);
        reg_rd(5'h10, rd); chk("R8 wptr held", rd, 32'h1000);
        chk("R8 input stopped", 32'(trc_ready), 0);
        reg_wr(5'h00, 32'd1);
        reg_rd(5'h14, rd); chk("R8 error cleared", rd, 0);
    endtask

    task automatic t_disable();
        b_delay = 12;
        push_n(4);
        reg_wr(5'h00, 32'd0);
        reg_rd(5'h14, rd); chk("R10 busy during burst", rd, 4);
        chk("R9 backpressure", 32'(trc_ready), 0);
        wait_b(7);
        b_delay = 0;
        reg_rd(5'h10, rd); chk("R9 burst finished", rd, 32'h1010);
        reg_rd(5'h14, rd); chk("R10 idle after", rd, 0);
        repeat (20) @(posedge clk);
        chk("R9 no new burst", aw_cnt, 7);
        chk("R9 still not ready", 32'(trc_ready), 0);
    endtask

    task automatic t_rebase();
        reg_wr(5'h04, 32'h2000);
        reg_rd(5'h10, rd); chk("R12 wptr reload", rd, 32'h2000);
    endtask

    task automatic t_stream();
        int bad = 0;
        chk("R3 beat total", w_idx, s_idx);
        for (int i = 0; i < s_idx && i < 64; i++) if (wlog[i] !== sent[i]) bad++;
        chk("R3 data order", bad, 0);
        chk("R3 wlast placement", wlast_bad, 0);
        chk("R3 strobes", strb_bad, 0);
        chk("R4 single outstanding", overlap, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog R1..: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        t_reset();
        t_config();
        t_full_burst();
        t_flush();
        t_wrap();
        t_error();
        t_disable();
        t_rebase();
        t_stream();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule